// File: doc/BRIEF.md
# S/PDIF Channel-Status and User-Bit Transmit Sequencer

This block supplies the per-frame channel-status (C) and user (U) bits to an S/PDIF transmitter, and reports whether the transmitter, the channel-status walk and the user stream are busy. A 192-bit channel-status page is presented as six 32-bit words. The sequencer walks it one bit per frame, least significant bit first, from the first word through the sixth, and then starts over. The C bit of a frame is used for both of its subframes. User words are written into a four-entry FIFO and are sent one bit per frame, LSB first, in the order they were written.

The surrounding transmitter pulses `frame_tick` once per frame boundary. A tick seen while `tx_en` is high starts or advances a frame. A tick seen while `tx_en` is low ends transmission. All outputs are registered and change in the cycle after the tick that starts a frame. They hold for the rest of that frame. The biphase encoder uses `block_first` to select the block-start preamble. Biphase coding and audio sample formatting are handled elsewhere.

Top module: `spdif_cs_seq`

## Requirements
- R1: `tx_busy` is 1 in the cycle after any cycle with `tx_en` high. Once set, it stays 1 until a `frame_tick` arrives while `tx_en` is low, and it is 0 in the cycle after that tick.
- R2: The first frame started after idle is frame 0 of a block. `block_first` is 1 exactly during frames whose index is a multiple of 192.
- R3: Frame n carries bit (n mod 32) of word ((n mod 192) / 32) as its C bit. Word 0 is `cs_page[31:0]` and word 5 is `cs_page[191:160]`. After word 5 the walk wraps to word 0.
- R4: A word is captured from `cs_page` at the frame that sends its bit 0. Later changes to `cs_page` do not alter the remaining bits of that word.
- R5: While `cs_en` is low, `cs_bit` is 0 and the frame position still advances.
- R6: `cs_busy` becomes 1 when word 0 is loaded with `cs_en` high. It becomes 0 when word 5 is loaded, or when transmission ends.
- R7: The user FIFO holds 4 words. A write while it is full is dropped.
- R8: A user word is taken from the FIFO at a frame start when no user word is in progress. Its bits go out LSB first, one per frame, for 32 frames, and words go out in write order.
- R9: `usr_bit` is 0 while `usr_en` is low or no user word is in progress. The FIFO is not drained while `usr_en` is low.
- R10: `usr_busy` is 1 while the transmitter is running, `usr_en` is high, and a user word is held or in progress. It drops after the last bit of the last word.
- R11: The tick that ends transmission clears `cs_bit`, `usr_bit`, `block_first` and `cs_busy`, and resets the frame position, so the next start is frame 0.
- R12: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| cs_en | input | 1 | Channel-status send enable |
| usr_en | input | 1 | User-data send enable |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| cs_page | input | CS_WORDS*WORD_W | Channel-status page, word 0 in the low bits |
| usr_wr | input | 1 | Write strobe into the user FIFO |
| usr_wdata | input | WORD_W | User word to write |
| cs_bit | output | 1 | C bit for the current frame |
| usr_bit | output | 1 | U bit for the current frame |
| block_first | output | 1 | Current frame is the first of a 192-frame block |
| tx_busy | output | 1 | Transmitter busy |
| cs_busy | output | 1 | Channel-status walk busy |
| usr_busy | output | 1 | User stream busy |

## Verification
If the bit or word position is off, `block_first` moves away from its 192-frame stride, and the C sequence shows the wrong bit in the first frame after the slip. A missing or stale word capture appears no later than the next word boundary, within 32 frames. A fault in the FIFO pointers or counts shows up as a user word out of order or repeated, or as a dropped word that gets sent anyway. A fault in the busy state shows up within one cycle of the tick, write or enable change that should have moved it.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

    // Frame control decoded once at the top and shared by both bit paths.
    typedef struct packed {
        logic adv;   // a frame starts or advances
        logic stop;  // transmission ends at this boundary
    } frm_ctl_t;

endpackage

// File: rtl/spdif_cs_walker.sv
module spdif_cs_walker
    import spdif_cs_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CS_WORDS = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  frm_ctl_t                     ctl,
    input  logic                         cs_en,
    input  logic [CS_WORDS*WORD_W-1:0]   page,
    output logic                         cs_bit,
    output logic                         block_first,
    output logic                         cs_busy
);
    localparam int BW = $clog2(WORD_W);
    localparam int WW = (CS_WORDS > 1) ? $clog2(CS_WORDS) : 1;
    localparam logic [WW-1:0] LAST_W = WW'(CS_WORDS - 1);
    localparam logic [BW-1:0] LAST_B = BW'(WORD_W - 1);

    typedef struct packed {
        logic [BW-1:0]     bitc;
        logic [WW-1:0]     word;
        logic [WORD_W-1:0] sh;
        logic              cbit;
        logic              first;
        logic              busy;
    } st_t;

    st_t q, d;

    logic [WORD_W-1:0] words [CS_WORDS];
    logic [WORD_W-1:0] cur_word;
    logic              next_bit;

    for (genvar g = 0; g < CS_WORDS; g++) begin : g_words
        assign words[g] = page[g*WORD_W +: WORD_W];
    end

    assign cur_word = words[q.word];

    always_comb begin
        d        = q;
        next_bit = 1'b0;
        if (ctl.stop) begin
            d = '0;
        end else if (ctl.adv) begin
            d.first = (q.bitc == '0) && (q.word == '0);
            if (q.bitc == '0) begin
                next_bit = cur_word[0];
                d.sh     = cur_word >> 1;
                if ((q.word == '0) && cs_en) d.busy = 1'b1;
                if (q.word == LAST_W)        d.busy = 1'b0;
            end else begin
                next_bit = q.sh[0];
                d.sh     = q.sh >> 1;
            end
            d.cbit = cs_en & next_bit;
            if (q.bitc == LAST_B) begin
                d.bitc = '0;
                d.word = (q.word == LAST_W) ? '0 : q.word + 1'b1;
            end else begin
                d.bitc = q.bitc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cs_bit      = q.cbit;
    assign block_first = q.first;
    assign cs_busy     = q.busy;

    a_r5_cs_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl.adv && !cs_en) |-> !cs_bit);

    a_r11_stop_clears_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl.stop) |-> (!cs_bit && !cs_busy && !block_first));

    a_r6_busy_at_block_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl.adv) && block_first) |-> (cs_busy == $past(cs_en)));

endmodule

// File: rtl/spdif_usr_fifo.sv
module spdif_usr_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WORD_W-1:0]            wdata,
    input  logic                         pop,
    output logic [WORD_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CW-1:0]                cnt;
    } st_t;

    st_t  q, d;
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != FULL_C);
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = (q.wp == LAST_P) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == LAST_P) ? '0 : q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign count = q.cnt;

    a_r7_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(push && !pop && (count != FULL_C)) |-> (count == CW'($past(count) + 1'b1)));

    a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $past(push && !pop && (count == FULL_C)) |-> (count == FULL_C));

endmodule

// File: rtl/spdif_usr_shift.sv
module spdif_usr_shift
    import spdif_cs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frm_ctl_t          ctl,
    input  logic              usr_en,
    input  logic              run_next,
    input  logic [CW-1:0]     fifo_cnt,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output logic              usr_bit,
    output logic              usr_busy
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_B = BW'(WORD_W - 1);

    typedef struct packed {
        logic              act;
        logic [BW-1:0]     bitc;
        logic [WORD_W-1:0] sh;
        logic              ubit;
        logic              busy;
    } st_t;

    st_t q, d;

    always_comb begin
        d   = q;
        pop = 1'b0;
        if (ctl.stop) begin
            d.act  = 1'b0;
            d.bitc = '0;
            d.sh   = '0;
            d.ubit = 1'b0;
        end else if (ctl.adv) begin
            if (!usr_en) begin
                d.ubit = 1'b0;
            end else if (q.act) begin
                d.ubit = q.sh[0];
                d.sh   = q.sh >> 1;
                if (q.bitc == LAST_B) begin
                    d.act  = 1'b0;
                    d.bitc = '0;
                end else begin
                    d.bitc = q.bitc + 1'b1;
                end
            end else if (fifo_cnt != '0) begin
                pop    = 1'b1;
                d.ubit = head[0];
                d.sh   = head >> 1;
                d.bitc = BW'(1);
                d.act  = 1'b1;
            end else begin
                d.ubit = 1'b0;
            end
        end
        d.busy = run_next && usr_en && ((fifo_cnt > CW'(pop)) || d.act);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign usr_bit  = q.ubit;
    assign usr_busy = q.busy;

    a_r9_u_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl.adv && !usr_en) |-> !usr_bit);

    a_r10_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        usr_busy |-> $past(usr_en));

endmodule

// File: rtl/spdif_cs_seq.sv
module spdif_cs_seq
    import spdif_cs_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CS_WORDS = 6,
    parameter int UF_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_en,
    input  logic                       cs_en,
    input  logic                       usr_en,
    input  logic                       frame_tick,
    input  logic [CS_WORDS*WORD_W-1:0] cs_page,
    input  logic                       usr_wr,
    input  logic [WORD_W-1:0]          usr_wdata,
    output logic                       cs_bit,
    output logic                       usr_bit,
    output logic                       block_first,
    output logic                       tx_busy,
    output logic                       cs_busy,
    output logic                       usr_busy
);
    localparam int CW = $clog2(UF_DEPTH + 1);

    typedef struct packed {
        logic busy;
    } st_t;

    st_t               q, d;
    frm_ctl_t          ctl;
    logic              fifo_pop;
    logic [WORD_W-1:0] fifo_head;
    logic [CW-1:0]     fifo_cnt;

    always_comb begin
        d        = q;
        ctl.adv  = frame_tick && tx_en;
        ctl.stop = frame_tick && !tx_en && q.busy;
        d.busy   = tx_en || (q.busy && !frame_tick);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_busy = q.busy;

    spdif_cs_walker #(.WORD_W(WORD_W), .CS_WORDS(CS_WORDS)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .cs_en       (cs_en),
        .page        (cs_page),
        .cs_bit      (cs_bit),
        .block_first (block_first),
        .cs_busy     (cs_busy)
    );

    spdif_usr_fifo #(.WORD_W(WORD_W), .DEPTH(UF_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (usr_wr),
        .wdata (usr_wdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (fifo_cnt)
    );

    spdif_usr_shift #(.WORD_W(WORD_W), .CW(CW)) u_ushift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .usr_en   (usr_en),
        .run_next (d.busy),
        .fifo_cnt (fifo_cnt),
        .head     (fifo_head),
        .pop      (fifo_pop),
        .usr_bit  (usr_bit),
        .usr_busy (usr_busy)
    );

    a_r1_busy_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_en) |-> tx_busy);

    a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_busy && !frame_tick) |-> tx_busy);

    a_r1_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(frame_tick && !tx_en));

endmodule

// File: tb/tb_spdif_cs_seq.sv
module tb_spdif_cs_seq;
    localparam int W = 32;
    localparam int NW = 6;
    localparam int PB = W * NW;

    // bit 192 = cs_en, bits 191:0 = page
    localparam logic [PB:0] VEC [4] = '{
        {1'b1, 32'hF0F01234, 32'h80000001, 32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF, 32'hA5C30F96},
        {1'b1, 32'h13579BDF, 32'h2468ACE0, 32'h0F0F0F0F, 32'h55555555, 32'h00010000, 32'h7FFFFFFE},
        {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {1'b1, 32'h00000001, 32'h00000002, 32'h00000004, 32'h00000008, 32'h00000010, 32'h00000020}
    };
    localparam logic [W-1:0] UW [5] = '{32'hC0FFEE01, 32'h12345678, 32'h8000000F, 32'hA5A5A5A5, 32'hFFFFFFFF};

    logic clk = 0, rst_n = 0;
    logic tx_en = 0, cs_en = 0, usr_en = 0, frame_tick = 0, usr_wr = 0;
    logic [PB-1:0] cs_page = '0;
    logic [W-1:0]  usr_wdata = '0;
    logic cs_bit, usr_bit, block_first, tx_busy, cs_busy, usr_busy;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spdif_cs_seq dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cs_en(cs_en), .usr_en(usr_en),
        .frame_tick(frame_tick), .cs_page(cs_page), .usr_wr(usr_wr), .usr_wdata(usr_wdata),
        .cs_bit(cs_bit), .usr_bit(usr_bit), .block_first(block_first),
        .tx_busy(tx_busy), .cs_busy(cs_busy), .usr_busy(usr_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) frame_tick = 1;
        @(negedge clk) frame_tick = 0;
    endtask

    task automatic stop_tx();
        @(negedge clk) tx_en = 0;
        @(negedge clk);
        chk("R1 busy held until tick", tx_busy, 1);
        tick();
        chk("R1 busy cleared by tick", tx_busy, 0);
        chk("R11 cs_bit cleared", cs_bit, 0);
        chk("R11 usr_bit cleared", usr_bit, 0);
        chk("R11 block_first cleared", block_first, 0);
        chk("R11 cs_busy cleared", cs_busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [PB-1:0] pg, pg2;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 cs_bit", cs_bit, 0);
        chk("R12 usr_bit", usr_bit, 0);
        chk("R12 block_first", block_first, 0);
        chk("R12 tx_busy", tx_busy, 0);
        chk("R12 cs_busy", cs_busy, 0);
        chk("R12 usr_busy", usr_busy, 0);
        rst_n = 1;

        // Table walk: R2, R3, R5, R6, R11 restart at frame 0
        for (int v = 0; v < 4; v++) begin
            cs_page = VEC[v][PB-1:0];
            cs_en   = VEC[v][PB];
            @(negedge clk) tx_en = 1;
            @(negedge clk);
            chk("R1 busy after enable", tx_busy, 1);
            for (int n = 0; n < 200; n++) begin
                int p;
                p = n % PB;
                tick();
                chk("R2 block_first", block_first, (p == 0));
                chk("R3 R5 cs_bit", cs_bit, VEC[v][PB] & VEC[v][p]);
                chk("R6 cs_busy", cs_busy, VEC[v][PB] && ((p / W) != NW - 1));
            end
            stop_tx();
        end

        // R4: word captured at its first frame
        pg = VEC[0][PB-1:0];
        cs_page = pg;
        cs_en = 1;
        @(negedge clk) tx_en = 1;
        tick();
        pg2 = pg ^ {{(PB-2*W){1'b0}}, {(2*W){1'b1}}};
        cs_page = pg2;
        for (int n = 1; n < 40; n++) begin
            tick();
            if (n < W) chk("R4 old word kept", cs_bit, pg[n]);
            else       chk("R4 next word new", cs_bit, pg2[n]);
        end
        stop_tx();

        // R7..R10: user FIFO and user bits
        cs_en = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) begin usr_wr = 1; usr_wdata = UW[k]; end
        end
        @(negedge clk) usr_wr = 0;
        @(negedge clk) tx_en = 1;
        @(negedge clk);
        chk("R10 busy needs usr_en", usr_busy, 0);
        for (int n = 0; n < 3; n++) begin
            tick();
            chk("R9 U quiet when disabled", usr_bit, 0);
        end
        @(negedge clk) usr_en = 1;
        @(negedge clk);
        chk("R10 busy with data", usr_busy, 1);
        for (int k = 0; k < 4 * W; k++) begin
            tick();
            chk("R8 user bit order", usr_bit, UW[k / W][k % W]);
            if (k == 4 * W - 2) chk("R10 busy during last word", usr_busy, 1);
            if (k == 4 * W - 1) chk("R10 busy drops after last bit", usr_busy, 0);
        end
        for (int n = 0; n < 3; n++) begin
            tick();
            chk("R7 R9 dropped word not sent", usr_bit, 0);
        end
        chk("R7 busy stays low, no fifth word", usr_busy, 0);
        stop_tx();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule